// File: doc/BRIEF.md
# I2C Slave Address Match and Status Flags

This block sits next to an I2C byte engine and holds the status flags a processor polls while the engine moves bytes. The engine reports bus START and STOP events, each received 7-bit calling address with its read/write bit, and the end of every byte. The processor reports its control-register writes and its data-register reads and writes, and says whether the port is transmitting or receiving.

The block checks each calling address against several sources. These are the primary own address, an optional second address, an address window spanned by the primary address and a range bound, the general call, and the SMBus alert response address. A match raises the addressed flag and the transfer-complete flag. It also latches the read/write bit and pulses an ACK-enable strobe, all early enough to acknowledge the address byte.

Every interface is a plain strobe or level; there is no back-pressure. Each strobe is honoured in the single clock cycle in which it is high.

Top module: `i2c_slv_status`

## Requirements
- R1: After reset, tcf is 1 and aas, busy, srw and ack_en are 0.
- R2: When addr_vld is high and addr_in equals cfg_pri, aas is 1 from the next cycle on, and ack_en is high for exactly that one cycle.
- R3: With en_rng high and cfg_rng nonzero, an address matches when it lies between cfg_pri and cfg_rng, with both bounds included and either bound allowed to be the larger. With cfg_rng zero, no window or range match occurs.
- R4: With en_gc high, address 7'h00 with addr_rw 0 (write) matches. Address 7'h00 with addr_rw 1 does not match, and neither does any address while en_gc is low.
- R5: With en_sec high, address cfg_sec matches. With en_sec low, it does not.
- R6: With en_alert high, address 7'h0C matches in either direction. With en_alert low, it does not.
- R7: A calling address that no enabled source matches leaves aas, tcf and srw unchanged and gives no ack_en pulse.
- R8: A ctl_wr pulse clears aas on the next cycle, whatever value is written. If a matching addr_vld arrives in the same cycle, aas ends up 1.
- R9: Any address match sets tcf on the next cycle.
- R10: byte_done sets tcf. With tx_mode 0, dat_rd clears it and dat_wr has no effect. With tx_mode 1, dat_wr clears it and dat_rd has no effect. If a set and a clear arrive in the same cycle, the set wins.
- R11: start_det sets busy and stop_det clears it. If both arrive in the same cycle, busy ends up 1.
- R12: srw takes the addr_rw value of each matched address and holds it through cycles without a match, including cycles with a non-matching address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_det | input | 1 | START seen on the bus |
| stop_det | input | 1 | STOP seen on the bus |
| addr_vld | input | 1 | Calling address valid strobe |
| addr_in | input | 7 | Received calling address |
| addr_rw | input | 1 | R/W bit of the calling address (1 = read) |
| byte_done | input | 1 | Byte transfer finished |
| ctl_wr | input | 1 | Control-register write |
| dat_rd | input | 1 | Data-register read |
| dat_wr | input | 1 | Data-register write |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| cfg_pri | input | 7 | Primary own address |
| cfg_sec | input | 7 | Second own address |
| cfg_rng | input | 7 | Range bound address |
| en_rng | input | 1 | Enable range matching |
| en_gc | input | 1 | Enable general call |
| en_sec | input | 1 | Enable second address |
| en_alert | input | 1 | Enable alert response address |
| tcf | output | 1 | Transfer complete flag |
| aas | output | 1 | Addressed as slave flag |
| busy | output | 1 | Bus busy flag |
| srw | output | 1 | Latched slave read/write bit |
| ack_en | output | 1 | One-cycle strobe: acknowledge this address |

## Verification
The match logic is tried with addresses inside the window, on each bound, and one step outside it, with the range bound set both above and below the primary address. This separates an inclusive test from an exclusive one and an ordered comparison from one that is independent of order. The reserved addresses are each sent with the matching enable set and then cleared. The general call is also sent as a read, which shows whether the direction bit is taken into account. The flag tests put each access next to its counterpart: a data read against a data write in both modes, a set and a clear in the same cycle, and a non-matching address after a matched read. This shows that each clear, each priority rule and each hold is tied to the right event.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int GC_CODE    = 0;
  localparam int ALERT_CODE = 12;
endpackage

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_slv_pkg::*;
#(
  parameter int AW        = 7,
  parameter bit HAS_RANGE = 1'b1
) (
  input  logic [AW-1:0] addr_in,
  input  logic          addr_rw,
  input  logic [AW-1:0] cfg_pri,
  input  logic [AW-1:0] cfg_sec,
  input  logic [AW-1:0] cfg_rng,
  input  logic          en_rng,
  input  logic          en_gc,
  input  logic          en_sec,
  input  logic          en_alert,
  output logic          hit
);
  localparam logic [AW-1:0] GC_A    = AW'(GC_CODE);
  localparam logic [AW-1:0] ALERT_A = AW'(ALERT_CODE);
  localparam int NSRC = 5;

  logic [NSRC-1:0] src_hit;

  assign src_hit[0] = (addr_in == cfg_pri);
  assign src_hit[1] = en_gc && (addr_in == GC_A) && !addr_rw;
  assign src_hit[2] = en_sec && (addr_in == cfg_sec);
  assign src_hit[3] = en_alert && (addr_in == ALERT_A);

  generate
    if (HAS_RANGE) begin : g_range
      logic [AW-1:0] lo_b, hi_b;
      logic          rng_ok;
      assign rng_ok = en_rng && (cfg_rng != '0);
      // the window is the same whichever bound is the larger one
      assign lo_b = (cfg_pri < cfg_rng) ? cfg_pri : cfg_rng;
      assign hi_b = (cfg_pri < cfg_rng) ? cfg_rng : cfg_pri;
      assign src_hit[4] = rng_ok && (addr_in >= lo_b) && (addr_in <= hi_b);
    end else begin : g_norange
      assign src_hit[4] = 1'b0;
    end
  endgenerate

  assign hit = |src_hit;
endmodule

// File: rtl/i2c_bus_state.sv
module i2c_bus_state (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (!rst_n)         busy <= 1'b0;
    else if (start_det) busy <= 1'b1;
    else if (stop_det)  busy <= 1'b0;
  end

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> !busy);
endmodule

// File: rtl/i2c_xfer_flags.sv
module i2c_xfer_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_vld,
  input  logic addr_rw,
  input  logic hit,
  input  logic byte_done,
  input  logic ctl_wr,
  input  logic dat_rd,
  input  logic dat_wr,
  input  logic tx_mode,
  output logic tcf,
  output logic aas,
  output logic srw,
  output logic ack_en
);
  logic take, tcf_clr;

  assign take    = addr_vld && hit;
  assign tcf_clr = tx_mode ? dat_wr : dat_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcf    <= 1'b1;
      aas    <= 1'b0;
      srw    <= 1'b0;
      ack_en <= 1'b0;
    end else begin
      ack_en <= take;
      if (take)        aas <= 1'b1;
      else if (ctl_wr) aas <= 1'b0;
      if (take || byte_done) tcf <= 1'b1;
      else if (tcf_clr)      tcf <= 1'b0;
      if (take) srw <= addr_rw;
    end
  end

  p_ack_has_aas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> aas);
  p_ack_has_tcf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> tcf);
  p_ctl_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !addr_vld) |=> !aas);
  p_done_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> tcf);
  p_srw_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(srw));
endmodule

// File: rtl/i2c_slv_status.sv
module i2c_slv_status #(
  parameter int AW        = 7,
  parameter bit HAS_RANGE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr_in,
  input  logic          addr_rw,
  input  logic          byte_done,
  input  logic          ctl_wr,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic          tx_mode,
  input  logic [AW-1:0] cfg_pri,
  input  logic [AW-1:0] cfg_sec,
  input  logic [AW-1:0] cfg_rng,
  input  logic          en_rng,
  input  logic          en_gc,
  input  logic          en_sec,
  input  logic          en_alert,
  output logic          tcf,
  output logic          aas,
  output logic          busy,
  output logic          srw,
  output logic          ack_en
);
  logic hit;

  i2c_addr_match #(.AW(AW), .HAS_RANGE(HAS_RANGE)) u_match (
    .addr_in(addr_in), .addr_rw(addr_rw), .cfg_pri(cfg_pri), .cfg_sec(cfg_sec),
    .cfg_rng(cfg_rng), .en_rng(en_rng), .en_gc(en_gc), .en_sec(en_sec),
    .en_alert(en_alert), .hit(hit)
  );

  i2c_xfer_flags u_flags (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_rw(addr_rw), .hit(hit),
    .byte_done(byte_done), .ctl_wr(ctl_wr), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .tx_mode(tx_mode), .tcf(tcf), .aas(aas), .srw(srw), .ack_en(ack_en)
  );

  i2c_bus_state u_bus (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det), .busy(busy)
  );

  p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !addr_vld) |=> !ack_en);
endmodule

// File: tb/tb_i2c_slv_status.sv
module tb_i2c_slv_status;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_det = 0, stop_det = 0, addr_vld = 0, addr_rw = 0, byte_done = 0;
  logic ctl_wr = 0, dat_rd = 0, dat_wr = 0, tx_mode = 0;
  logic en_rng = 0, en_gc = 0, en_sec = 0, en_alert = 0;
  logic [6:0] addr_in = '0, cfg_pri = 7'h50, cfg_sec = 7'h33, cfg_rng = '0;
  logic tcf, aas, busy, srw, ack_en;
  int n_chk = 0, n_bad = 0;
  logic got_ack;

  always #(CLK_PER/2) clk = ~clk;

  i2c_slv_status dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .addr_vld(addr_vld), .addr_in(addr_in), .addr_rw(addr_rw), .byte_done(byte_done),
    .ctl_wr(ctl_wr), .dat_rd(dat_rd), .dat_wr(dat_wr), .tx_mode(tx_mode),
    .cfg_pri(cfg_pri), .cfg_sec(cfg_sec), .cfg_rng(cfg_rng), .en_rng(en_rng),
    .en_gc(en_gc), .en_sec(en_sec), .en_alert(en_alert),
    .tcf(tcf), .aas(aas), .busy(busy), .srw(srw), .ack_en(ack_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one-cycle address strobe; got_ack holds ack_en seen the cycle after
  task automatic send_addr(input logic [6:0] a, input logic rw);
    addr_in = a; addr_rw = rw; addr_vld = 1;
    @(negedge clk);
    addr_vld = 0;
    got_ack = ack_en;
  endtask

  task automatic pulse_ctl();
    ctl_wr = 1; @(negedge clk); ctl_wr = 0;
  endtask

  // expect match or not from a clean aas state
  task automatic try_addr(input string req, input logic [6:0] a, input logic rw, input logic exp);
    pulse_ctl();
    send_addr(a, rw);
    chk(req, $sformatf("aas for %h", a), aas, exp);
    chk(req, $sformatf("ack for %h", a), got_ack, exp);
  endtask

  task automatic t_reset();
    chk("R1", "tcf", tcf, 1'b1);
    chk("R1", "aas", aas, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "srw", srw, 1'b0);
    chk("R1", "ack_en", ack_en, 1'b0);
  endtask

  task automatic t_primary();
    try_addr("R2", 7'h50, 1'b0, 1'b1);
    @(negedge clk);
    chk("R2", "ack drops", ack_en, 1'b0);
    chk("R2", "aas holds", aas, 1'b1);
  endtask

  task automatic t_range();
    cfg_pri = 7'h20; en_rng = 1; cfg_rng = 7'h28;
    try_addr("R3", 7'h24, 0, 1);
    try_addr("R3", 7'h28, 0, 1);
    try_addr("R3", 7'h29, 0, 0);
    try_addr("R3", 7'h1F, 0, 0);
    cfg_rng = 7'h18;
    try_addr("R3", 7'h18, 0, 1);
    try_addr("R3", 7'h1C, 1, 1);
    try_addr("R3", 7'h17, 0, 0);
    cfg_rng = 7'h00;
    try_addr("R3", 7'h10, 0, 0);
    cfg_rng = 7'h28; en_rng = 0;
    try_addr("R3", 7'h24, 0, 0);
    cfg_pri = 7'h50;
  endtask

  task automatic t_gc();
    en_gc = 1;
    try_addr("R4", 7'h00, 0, 1);
    try_addr("R4", 7'h00, 1, 0);
    en_gc = 0;
    try_addr("R4", 7'h00, 0, 0);
  endtask

  task automatic t_second();
    en_sec = 1; try_addr("R5", 7'h33, 0, 1);
    en_sec = 0; try_addr("R5", 7'h33, 0, 0);
  endtask

  task automatic t_alert();
    en_alert = 1; try_addr("R6", 7'h0C, 1, 1);
    try_addr("R6", 7'h0C, 0, 1);
    en_alert = 0; try_addr("R6", 7'h0C, 1, 0);
  endtask

  task automatic t_nomatch();
    tx_mode = 0;
    send_addr(7'h50, 1'b1);           // match: aas=1, srw=1, tcf=1
    dat_rd = 1; @(negedge clk); dat_rd = 0;
    chk("R7", "tcf cleared first", tcf, 0);
    send_addr(7'h11, 1'b0);
    chk("R7", "no ack", got_ack, 0);
    chk("R7", "tcf held", tcf, 0);
    chk("R7", "aas held", aas, 1);
    chk("R7", "srw held", srw, 1);
  endtask

  task automatic t_ctl();
    send_addr(7'h50, 0);
    chk("R8", "aas set", aas, 1);
    pulse_ctl();
    chk("R8", "aas cleared", aas, 0);
    ctl_wr = 1;
    send_addr(7'h50, 0);
    ctl_wr = 0;
    chk("R8", "set wins", aas, 1);
  endtask

  task automatic t_match_tcf();
    tx_mode = 1;
    dat_wr = 1; @(negedge clk); dat_wr = 0;
    chk("R9", "tcf low", tcf, 0);
    send_addr(7'h50, 0);
    chk("R9", "match sets tcf", tcf, 1);
  endtask

  task automatic t_tcf_dir();
    tx_mode = 0;
    dat_wr = 1; @(negedge clk); dat_wr = 0;
    chk("R10", "rx write ignored", tcf, 1);
    dat_rd = 1; @(negedge clk); dat_rd = 0;
    chk("R10", "rx read clears", tcf, 0);
    byte_done = 1; @(negedge clk); byte_done = 0;
    chk("R10", "done sets", tcf, 1);
    tx_mode = 1;
    dat_rd = 1; @(negedge clk); dat_rd = 0;
    chk("R10", "tx read ignored", tcf, 1);
    dat_wr = 1; @(negedge clk); dat_wr = 0;
    chk("R10", "tx write clears", tcf, 0);
    dat_wr = 1; byte_done = 1; @(negedge clk); dat_wr = 0; byte_done = 0;
    chk("R10", "set beats clear", tcf, 1);
  endtask

  task automatic t_busy();
    start_det = 1; @(negedge clk); start_det = 0;
    chk("R11", "start", busy, 1);
    stop_det = 1; @(negedge clk); stop_det = 0;
    chk("R11", "stop", busy, 0);
    start_det = 1; stop_det = 1; @(negedge clk); start_det = 0; stop_det = 0;
    chk("R11", "both", busy, 1);
  endtask

  task automatic t_srw();
    send_addr(7'h50, 1);
    chk("R12", "read latched", srw, 1);
    send_addr(7'h12, 0);
    chk("R12", "non-match holds", srw, 1);
    @(negedge clk);
    chk("R12", "idle holds", srw, 1);
    send_addr(7'h50, 0);
    chk("R12", "write latched", srw, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_range();
    t_gc();
    t_second();
    t_alert();
    t_nomatch();
    t_ctl();
    t_match_tcf();
    t_tcf_dir();
    t_busy();
    t_srw();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule